// File: doc/BRIEF.md
# Tag-Only Cache Performance Model

This block models the hit and miss behaviour of a set-associative data cache without holding any data. It keeps a tag, a valid bit, a dirty bit and a recency stamp for every line. A driver feeds it one memory reference per cycle. Each reference is a read or a write to a byte address. For each reference the block reports whether it hit and whether a dirty line had to be written back. It also keeps running totals of reads, read misses, writes, write misses and writebacks, and the memory-stall cycles that these events imply.

Capacity, line size and associativity are given at compile time, in bytes for capacity and line size. The number of sets is capacity / (line size × associativity). An associativity of one gives a direct-mapped cache. An associativity of capacity / line size gives a fully associative cache. Writes follow a write-back, write-allocate policy. Victims are picked by least-recent use: a global reference counter stamps each line whenever that line is touched.

Top module: `tag_cache_model`

## Requirements
- R1: The address splits into log2(LINE_BYTES) offset bits at the bottom, then log2(sets) index bits, with the tag in the remaining upper bits. References that differ only in offset map to the same line. References with the same tag but different index occupy separate lines.
- R2: A read miss allocates the line, so a repeat read of the same line hits. A read hit changes only the line's stamp.
- R3: A write miss allocates the line and marks it dirty, and a write hit marks it dirty. Evicting a dirty line raises rsp_wb in that reference's response and increments cnt_wb. Evicting a clean line does neither.
- R4: On a miss, an invalid way of the set is filled before any recency comparison takes place. Among several invalid ways, the lowest-numbered one is filled.
- R5: When all ways of the set are valid, the way with the smallest stamp is evicted. A line's stamp is the value the global reference counter had after its most recent reference. On equal stamps the lowest-numbered way is evicted.
- R6: cnt_reads and cnt_writes count every accepted read and write. cnt_read_miss and cnt_write_miss count those that missed.
- R7: stall_cycles grows by a penalty of 12 + LINE_BYTES/8 for every read miss, every write miss and every dirty writeback.
- R8: An accepted reference (req_valid high, clear low) produces a one-cycle rsp_valid pulse on the next cycle, together with rsp_hit and rsp_wb. Cycles without a request produce no response and leave every counter unchanged.
- R9: clear invalidates every line and zeroes every counter, the reference counter and the overflow flag. A request in the same cycle as clear is ignored.
- R10: The reference counter is STAMP_W bits wide and does not wrap. The reference arriving while it holds its maximum value sets stamp_ovf, which stays set until clear or reset.
- R11: After reset, every counter is zero, rsp_valid and stamp_ovf are low, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous flush of all lines and statistics |
| req_valid | input | 1 | A reference is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the reference |
| rsp_valid | output | 1 | Result of the previous cycle's reference |
| rsp_hit | output | 1 | That reference hit |
| rsp_wb | output | 1 | That reference evicted a dirty line |
| cnt_reads | output | CNT_W | Total reads |
| cnt_read_miss | output | CNT_W | Reads that missed |
| cnt_writes | output | CNT_W | Total writes |
| cnt_write_miss | output | CNT_W | Writes that missed |
| cnt_wb | output | CNT_W | Dirty lines written back |
| stall_cycles | output | CNT_W | Accumulated memory-stall cycles |
| stamp_ovf | output | 1 | Sticky reference-counter saturation flag |

## Verification
The bench builds the block with 256 bytes of capacity, 16-byte lines and two ways. This gives eight sets and a 14-cycle penalty. The random traffic draws from only five tags per set, so hits, clean evictions and dirty evictions all occur often within a few hundred references. An 8-bit stamp lets a short run saturate the reference counter, which reaches the overflow flag and the equal-stamp tie-break within the cycle limit.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

   typedef enum logic {
      REF_READ  = 1'b0,
      REF_WRITE = 1'b1
   } ref_kind_e;

   function automatic int unsigned tcm_penalty(int unsigned line_bytes);
      return 12 + line_bytes / 8;
   endfunction

   function automatic bit tcm_is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tcm_addr_split.sv
module tcm_addr_split #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 4,
   parameter int unsigned SETS   = 8,
   localparam int unsigned IDX_BITS = $clog2(SETS),
   localparam int unsigned IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1,
   localparam int unsigned TAG_W    = ADDR_W - OFF_W - IDX_BITS
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  index,
   output logic [TAG_W-1:0]  tag
);

   assign tag = addr[ADDR_W-1 -: TAG_W];

   generate
      if (IDX_BITS == 0) begin : g_one_set
         assign index = '0;
      end else begin : g_many_sets
         assign index = addr[OFF_W +: IDX_BITS];
      end
   endgenerate

endmodule

// File: rtl/tcm_way_select.sv
module tcm_way_select #(
   parameter int unsigned WAYS    = 2,
   parameter int unsigned TAG_W   = 20,
   parameter int unsigned STAMP_W = 32,
   localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]              set_vld,
   input  logic [WAYS-1:0][TAG_W-1:0]   set_tag,
   input  logic [WAYS-1:0][STAMP_W-1:0] set_stamp,
   input  logic [TAG_W-1:0]             req_tag,
   output logic                         hit,
   output logic [WAY_W-1:0]             hit_way,
   output logic [WAY_W-1:0]             victim_way
);

   logic               any_free;
   logic [WAY_W-1:0]   free_way;
   logic [WAY_W-1:0]   lru_way;
   logic [STAMP_W-1:0] lru_stamp;

   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (set_vld[w] && (set_tag[w] == req_tag)) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
   end

   // Invalid ways win first; scanning downwards leaves the lowest one.
   always_comb begin
      any_free = 1'b0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!set_vld[w]) begin
            any_free = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

   // Strict less-than keeps the lowest way on equal stamps.
   always_comb begin
      lru_way   = '0;
      lru_stamp = set_stamp[0];
      for (int w = 1; w < WAYS; w++) begin
         if (set_stamp[w] < lru_stamp) begin
            lru_stamp = set_stamp[w];
            lru_way   = WAY_W'(w);
         end
      end
   end

   assign victim_way = any_free ? free_way : lru_way;

endmodule

// File: rtl/tcm_stamp_ctr.sv
module tcm_stamp_ctr #(
   parameter int unsigned STAMP_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               step,
   output logic [STAMP_W-1:0] next_stamp,
   output logic               ovf
);

   logic [STAMP_W-1:0] ref_q;
   logic               at_max;

   assign at_max     = (ref_q == {STAMP_W{1'b1}});
   assign next_stamp = at_max ? ref_q : ref_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
         ovf   <= 1'b0;
      end else if (clear) begin
         ref_q <= '0;
         ovf   <= 1'b0;
      end else if (step) begin
         ref_q <= next_stamp;
         if (at_max) ovf <= 1'b1;
      end
   end

endmodule

// File: rtl/tcm_stats.sv
module tcm_stats #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned PENALTY = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             ev_valid,
   input  logic             ev_write,
   input  logic             ev_hit,
   input  logic             ev_wb,
   output logic [CNT_W-1:0] cnt_reads,
   output logic [CNT_W-1:0] cnt_read_miss,
   output logic [CNT_W-1:0] cnt_writes,
   output logic [CNT_W-1:0] cnt_write_miss,
   output logic [CNT_W-1:0] cnt_wb,
   output logic [CNT_W-1:0] stall_cycles
);

   localparam logic [CNT_W-1:0] PEN = CNT_W'(PENALTY);

   logic [CNT_W-1:0] stall_add;

   assign stall_add = (ev_hit ? '0 : PEN) + (ev_wb ? PEN : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_reads      <= '0;
         cnt_read_miss  <= '0;
         cnt_writes     <= '0;
         cnt_write_miss <= '0;
         cnt_wb         <= '0;
         stall_cycles   <= '0;
      end else if (clear) begin
         cnt_reads      <= '0;
         cnt_read_miss  <= '0;
         cnt_writes     <= '0;
         cnt_write_miss <= '0;
         cnt_wb         <= '0;
         stall_cycles   <= '0;
      end else if (ev_valid) begin
         if (ev_write) begin
            cnt_writes <= cnt_writes + 1'b1;
            if (!ev_hit) cnt_write_miss <= cnt_write_miss + 1'b1;
         end else begin
            cnt_reads <= cnt_reads + 1'b1;
            if (!ev_hit) cnt_read_miss <= cnt_read_miss + 1'b1;
         end
         if (ev_wb) cnt_wb <= cnt_wb + 1'b1;
         stall_cycles <= stall_cycles + stall_add;
      end
   end

endmodule

// File: rtl/tag_cache_model.sv
module tag_cache_model
   import tcm_pkg::*;
#(
   parameter int unsigned CAP_BYTES  = 1024,
   parameter int unsigned LINE_BYTES = 16,
   parameter int unsigned WAYS       = 2,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned STAMP_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_wb,
   output logic [CNT_W-1:0]  cnt_reads,
   output logic [CNT_W-1:0]  cnt_read_miss,
   output logic [CNT_W-1:0]  cnt_writes,
   output logic [CNT_W-1:0]  cnt_write_miss,
   output logic [CNT_W-1:0]  cnt_wb,
   output logic [CNT_W-1:0]  stall_cycles,
   output logic              stamp_ovf
);

   localparam int unsigned LINES    = CAP_BYTES / LINE_BYTES;
   localparam int unsigned SETS     = LINES / WAYS;
   localparam int unsigned OFF_W    = $clog2(LINE_BYTES);
   localparam int unsigned IDX_BITS = $clog2(SETS);
   localparam int unsigned IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
   localparam int unsigned TAG_W    = ADDR_W - OFF_W - IDX_BITS;
   localparam int unsigned WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int unsigned PENALTY  = tcm_penalty(LINE_BYTES);

   generate
      if (!tcm_is_pow2(CAP_BYTES) || !tcm_is_pow2(LINE_BYTES) || !tcm_is_pow2(WAYS)) begin : g_bad_pow2
         $error("tag_cache_model: capacity, line size and ways must be powers of two");
      end
      if (WAYS > LINES) begin : g_bad_ways
         $error("tag_cache_model: more ways than lines");
      end
      if (ADDR_W <= OFF_W + IDX_BITS) begin : g_bad_addr
         $error("tag_cache_model: address too narrow for offset and index");
      end
   endgenerate

   logic                         accept;
   logic [IDX_W-1:0]             req_idx;
   logic [TAG_W-1:0]             req_tag;
   logic                         sel_hit;
   logic [WAY_W-1:0]             hit_way;
   logic [WAY_W-1:0]             victim_way;
   logic [WAY_W-1:0]             fill_way;
   logic                         evict_dirty;
   logic [STAMP_W-1:0]           new_stamp;

   logic [WAYS-1:0]              vld_q   [SETS];
   logic [WAYS-1:0]              dirty_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
   logic [WAYS-1:0][STAMP_W-1:0] stamp_q [SETS];

   assign accept = req_valid && !clear;

   tcm_addr_split #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .SETS   (SETS)
   ) u_split (
      .addr  (req_addr),
      .index (req_idx),
      .tag   (req_tag)
   );

   tcm_way_select #(
      .WAYS    (WAYS),
      .TAG_W   (TAG_W),
      .STAMP_W (STAMP_W)
   ) u_sel (
      .set_vld    (vld_q[req_idx]),
      .set_tag    (tag_q[req_idx]),
      .set_stamp  (stamp_q[req_idx]),
      .req_tag    (req_tag),
      .hit        (sel_hit),
      .hit_way    (hit_way),
      .victim_way (victim_way)
   );

   tcm_stamp_ctr #(
      .STAMP_W (STAMP_W)
   ) u_stamp (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .step       (accept),
      .next_stamp (new_stamp),
      .ovf        (stamp_ovf)
   );

   assign fill_way    = sel_hit ? hit_way : victim_way;
   assign evict_dirty = !sel_hit && vld_q[req_idx][victim_way] && dirty_q[req_idx][victim_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s]   <= '0;
            dirty_q[s] <= '0;
            tag_q[s]   <= '0;
            stamp_q[s] <= '0;
         end
      end else if (clear) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s]   <= '0;
            dirty_q[s] <= '0;
            tag_q[s]   <= '0;
            stamp_q[s] <= '0;
         end
      end else if (accept) begin
         vld_q[req_idx][fill_way]   <= 1'b1;
         tag_q[req_idx][fill_way]   <= req_tag;
         stamp_q[req_idx][fill_way] <= new_stamp;
         if (sel_hit)
            dirty_q[req_idx][fill_way] <= dirty_q[req_idx][fill_way] | (req_write == REF_WRITE);
         else
            dirty_q[req_idx][fill_way] <= (req_write == REF_WRITE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_wb    <= 1'b0;
      end else begin
         rsp_valid <= accept;
         rsp_hit   <= accept && sel_hit;
         rsp_wb    <= accept && evict_dirty;
      end
   end

   tcm_stats #(
      .CNT_W   (CNT_W),
      .PENALTY (PENALTY)
   ) u_stats (
      .clk            (clk),
      .rst_n          (rst_n),
      .clear          (clear),
      .ev_valid       (accept),
      .ev_write       (req_write),
      .ev_hit         (sel_hit),
      .ev_wb          (evict_dirty),
      .cnt_reads      (cnt_reads),
      .cnt_read_miss  (cnt_read_miss),
      .cnt_writes     (cnt_writes),
      .cnt_write_miss (cnt_write_miss),
      .cnt_wb         (cnt_wb),
      .stall_cycles   (stall_cycles)
   );

endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned LINE_BYTES = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic             req_valid,
   input logic             req_write,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic             rsp_wb,
   input logic [CNT_W-1:0] cnt_reads,
   input logic [CNT_W-1:0] cnt_read_miss,
   input logic [CNT_W-1:0] cnt_writes,
   input logic [CNT_W-1:0] cnt_write_miss,
   input logic [CNT_W-1:0] cnt_wb,
   input logic [CNT_W-1:0] stall_cycles,
   input logic             stamp_ovf
);

   localparam logic [CNT_W-1:0] PEN_V = CNT_W'(12 + LINE_BYTES / 8);

   a_r8_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !clear) |=> rsp_valid);

   a_r8_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || clear) |=> !rsp_valid);

   a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !clear) |=> ($stable(cnt_reads) && $stable(cnt_writes) && $stable(stall_cycles)));

   a_r3_wb_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_wb) |-> !rsp_hit);

   a_r6_read_step: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !clear && !req_write) |=> (cnt_reads == $past(cnt_reads) + 1'b1));

   a_r6_write_step: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !clear && req_write) |=> (cnt_writes == $past(cnt_writes) + 1'b1));

   a_r6_miss_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_read_miss <= cnt_reads) && (cnt_write_miss <= cnt_writes));

   a_r7_stall_step: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (stall_cycles == $past(stall_cycles) + (rsp_hit ? '0 : PEN_V) + (rsp_wb ? PEN_V : '0)));

   a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_reads == '0 && cnt_writes == '0 && cnt_wb == '0 && stall_cycles == '0 && !stamp_ovf));

   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stamp_ovf && !clear) |=> stamp_ovf);

endmodule

bind tag_cache_model tcm_checker #(
   .CNT_W      (CNT_W),
   .LINE_BYTES (LINE_BYTES)
) u_tcm_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .clear          (clear),
   .req_valid      (req_valid),
   .req_write      (req_write),
   .rsp_valid      (rsp_valid),
   .rsp_hit        (rsp_hit),
   .rsp_wb         (rsp_wb),
   .cnt_reads      (cnt_reads),
   .cnt_read_miss  (cnt_read_miss),
   .cnt_writes     (cnt_writes),
   .cnt_write_miss (cnt_write_miss),
   .cnt_wb         (cnt_wb),
   .stall_cycles   (stall_cycles),
   .stamp_ovf      (stamp_ovf)
);

// File: tb/tag_cache_model_bench.sv
module tag_cache_model_bench;

   localparam int CAP     = 256;
   localparam int LINE    = 16;
   localparam int WAYS    = 2;
   localparam int ADDR_W  = 16;
   localparam int CNT_W   = 24;
   localparam int STAMP_W = 8;
   localparam int SETS    = CAP / (LINE * WAYS);
   localparam int PEN     = 12 + LINE / 8;
   localparam int SMAX    = (1 << STAMP_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clear = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              rsp_valid, rsp_hit, rsp_wb, stamp_ovf;
   logic [CNT_W-1:0]  cnt_reads, cnt_read_miss, cnt_writes, cnt_write_miss, cnt_wb, stall_cycles;

   always #10 clk = ~clk;

   tag_cache_model #(
      .CAP_BYTES (CAP), .LINE_BYTES (LINE), .WAYS (WAYS),
      .ADDR_W (ADDR_W), .CNT_W (CNT_W), .STAMP_W (STAMP_W)
   ) u_tag_cache_model (
      .clk (clk), .rst_n (rst_n), .clear (clear),
      .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
      .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_wb (rsp_wb),
      .cnt_reads (cnt_reads), .cnt_read_miss (cnt_read_miss),
      .cnt_writes (cnt_writes), .cnt_write_miss (cnt_write_miss),
      .cnt_wb (cnt_wb), .stall_cycles (stall_cycles), .stamp_ovf (stamp_ovf)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // reference model state
   bit m_vld   [SETS][WAYS];
   bit m_dirty [SETS][WAYS];
   int m_tag   [SETS][WAYS];
   int m_stamp [SETS][WAYS];
   int m_ref, m_rd, m_rdm, m_wr, m_wrm, m_wb, m_stall;
   bit m_ovf;

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            m_vld[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = 0;
         end
      m_ref = 0; m_rd = 0; m_rdm = 0; m_wr = 0; m_wrm = 0; m_wb = 0; m_stall = 0; m_ovf = 0;
   endtask

   function automatic int mk(int tag, int idx, int off);
      return (tag << 7) | (idx << 4) | off;
   endfunction

   task automatic check_counts(string req);
      check({req, " reads"},      int'(cnt_reads),      m_rd);
      check({req, " read_miss"},  int'(cnt_read_miss),  m_rdm);
      check({req, " writes"},     int'(cnt_writes),     m_wr);
      check({req, " write_miss"}, int'(cnt_write_miss), m_wrm);
      check({req, " wb"},         int'(cnt_wb),         m_wb);
      check({req, " stall"},      int'(stall_cycles),   m_stall);
   endtask

   // Called at a falling edge; returns at the next falling edge after checking.
   task automatic do_ref(bit wr, int addr, string req);
      int idx, tag, way, stamp;
      bit hit, wb, any_free;
      idx = (addr >> 4) & (SETS - 1);
      tag = addr >> 7;
      hit = 0; way = 0;
      for (int w = 0; w < WAYS; w++)
         if (m_vld[idx][w] && m_tag[idx][w] == tag) begin hit = 1; way = w; end
      if (!hit) begin
         any_free = 0;
         for (int w = WAYS - 1; w >= 0; w--)
            if (!m_vld[idx][w]) begin any_free = 1; way = w; end
         if (!any_free) begin
            way = 0;
            for (int w = 1; w < WAYS; w++)
               if (m_stamp[idx][w] < m_stamp[idx][way]) way = w;
         end
      end
      wb = !hit && m_vld[idx][way] && m_dirty[idx][way];
      if (m_ref == SMAX) begin m_ovf = 1; stamp = SMAX; end
      else begin m_ref++; stamp = m_ref; end
      m_vld[idx][way] = 1; m_tag[idx][way] = tag; m_stamp[idx][way] = stamp;
      m_dirty[idx][way] = hit ? (m_dirty[idx][way] | wr) : wr;
      if (wr) begin m_wr++; if (!hit) m_wrm++; end
      else begin m_rd++; if (!hit) m_rdm++; end
      if (wb) m_wb++;
      m_stall += (hit ? 0 : PEN) + (wb ? PEN : 0);

      req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr);
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " R8 rsp_valid"}, int'(rsp_valid), 1);
      check({req, " hit"},          int'(rsp_hit),   int'(hit));
      check({req, " R3 wb"},        int'(rsp_wb),    int'(wb));
      check({req, " R10 ovf"},      int'(stamp_ovf), int'(m_ovf));
   endtask

   task automatic pulse_clear();
      clear = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(mk(1, 0, 0));
      @(negedge clk);
      clear = 1'b0; req_valid = 1'b0;
      model_clear();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h1bad_5eed));
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      check("R11 rsp_valid", int'(rsp_valid), 0);
      check("R11 ovf", int'(stamp_ovf), 0);
      check_counts("R11");

      // R2, R4: two misses fill way 0 then way 1, then both hit
      do_ref(0, mk(1, 0, 0), "R2 first read miss");
      do_ref(0, mk(2, 0, 4), "R4 second way fill");
      do_ref(0, mk(1, 0, 15), "R1 R2 offset change hits");
      do_ref(0, mk(2, 0, 0), "R2 read hit");
      // R5: tag2 most recent; tag1 is LRU and clean
      do_ref(0, mk(3, 0, 0), "R5 evict lru clean");
      do_ref(0, mk(2, 0, 0), "R5 recent kept");
      do_ref(0, mk(1, 0, 0), "R5 lru was evicted");
      // R1: same tag in another set is separate
      do_ref(0, mk(2, 5, 0), "R1 other index miss");
      do_ref(0, mk(2, 0, 0), "R1 original still present");
      // R3: write-allocate, dirty eviction
      do_ref(1, mk(4, 1, 0), "R3 write miss allocates");
      do_ref(0, mk(4, 1, 8), "R3 written line hits");
      do_ref(1, mk(5, 1, 0), "R3 second write");
      do_ref(0, mk(6, 1, 0), "R3 dirty eviction");
      do_ref(1, mk(6, 1, 0), "R3 write hit dirties");
      do_ref(0, mk(7, 1, 0), "R3 evict second dirty");
      do_ref(0, mk(4, 1, 0), "R3 evict dirty write-hit line");
      check_counts("R6 R7 directed");

      // R8: idle cycles leave counters alone
      repeat (4) @(negedge clk);
      check("R8 idle rsp", int'(rsp_valid), 0);
      check_counts("R8 idle");

      // Random mix, back-to-back
      for (int i = 0; i < 200; i++) begin
         do_ref(bit'($urandom % 2), mk($urandom % 5, $urandom % SETS, $urandom % LINE), "R6 random");
         if (($urandom % 8) == 0) @(negedge clk);
      end
      check_counts("R6 R7 random");

      // R9: clear flushes; simultaneous request ignored
      pulse_clear();
      check("R9 rsp after clear", int'(rsp_valid), 0);
      check_counts("R9");
      do_ref(0, mk(1, 0, 0), "R9 line gone after clear");

      // R10: saturate stamps, sticky flag, tie-break lowest way
      pulse_clear();
      for (int i = 0; i < SMAX + 20; i++)
         do_ref(bit'($urandom % 2), mk($urandom % 4, $urandom % SETS, 0), "R10 R5 saturating run");
      repeat (3) @(negedge clk);
      check("R10 ovf sticky", int'(stamp_ovf), 1);
      check_counts("R10");
      pulse_clear();
      check("R9 ovf cleared", int'(stamp_ovf), 0);

      finish_run();
   end

endmodule